// File: doc/BRIEF.md
# Legacy PC Memory Region Router

This block takes a single-byte physical memory access, a read or a write at a 32-bit address, and decides which backing store serves it under a fixed legacy PC memory map. First an address-line-20 gate is applied. Then the byte goes to one of three places: main RAM, a separate video memory port, or the upper 256 KB area from 0xC0000 to 0xFFFFF. That upper area holds option and system firmware, and any 16 KB segment of it can be shadowed into RAM.

Each of the sixteen upper-area segments has its own read attribute and its own write attribute. A small configuration port programs them. A global shadow-enable input turns the attribute logic off. Accesses at or beyond the installed memory size reach no store: reads return all ones and writes vanish. Port strobes are combinational in the request cycle, and the downstream stores answer in that same cycle. Read data comes back registered one cycle later, together with a valid strobe.

Top module: `pc_mem_router`

## Requirements
- R1: When `a20_gate_i` is 0, address bit 20 is cleared before any decoding and on every forwarded address. When it is 1, the address passes through unchanged.
- R2: An in-range address whose bits [31:19] are not 13'h0001 goes to the RAM port with the address unchanged, for both reads and writes.
- R3: Addresses 0x80000 to 0x9FFFF go to the RAM port for both reads and writes.
- R4: Addresses 0xA0000 to 0xBFFFF go to the video port for both reads and writes, and strobe no other port.
- R5: In 0xC0000 to 0xFFFFF the segment index is address bits [17:14]. Each of the 16 segments has a 2-bit read attribute and a 2-bit write attribute. A configuration write (`cfg_we_i`) loads both attributes of segment `cfg_seg_i` and takes effect on the next cycle. After reset, every attribute is 1.
- R6: An upper-area write whose segment write attribute is 0 goes to the RAM port. If the attribute is 1, the write strobes no port.
- R7: An upper-area read whose segment read attribute is 0 returns RAM data. If the attribute is 1, the read is sent to the ROM-copy port at offset address minus 0xC0000 (address bits [17:0]) and returns that port's data.
- R8: When `shadow_en_i` is 0, upper-area reads go to the RAM port and upper-area writes strobe no port, whatever the attributes hold.
- R9: An access whose masked address is at or above `MEM_BYTES` strobes no port. A read there returns 8'hFF. This check takes priority over the region decode.
- R10: An upper-area access with `shadow_en_i` = 1 whose relevant attribute is 2 or 3 strobes no port. `attr_err_o` is 1 in the following cycle, and a read returns 8'hFF.
- R11: `rsp_valid_o` and `rsp_rdata_o` are updated one cycle after a read request. `rsp_valid_o` stays 0 after writes and idle cycles, and both flags are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 8 | Write data |
| a20_gate_i | input | 1 | Address line 20 enable |
| shadow_en_i | input | 1 | Upper-area attribute logic enable |
| cfg_we_i | input | 1 | Attribute configuration write |
| cfg_seg_i | input | 4 | Segment index being configured |
| cfg_rd_attr_i | input | 2 | Read attribute to load |
| cfg_wr_attr_i | input | 2 | Write attribute to load |
| ram_req_o | output | 1 | RAM port strobe |
| ram_we_o | output | 1 | RAM port write |
| ram_addr_o | output | 32 | RAM port address |
| ram_wdata_o | output | 8 | RAM port write data |
| ram_rdata_i | input | 8 | RAM port read data, same cycle |
| vid_req_o | output | 1 | Video port strobe |
| vid_we_o | output | 1 | Video port write |
| vid_addr_o | output | 32 | Video port address |
| vid_wdata_o | output | 8 | Video port write data |
| vid_rdata_i | input | 8 | Video port read data, same cycle |
| rom_req_o | output | 1 | ROM-copy read strobe |
| rom_addr_o | output | 18 | ROM-copy offset |
| rom_rdata_i | input | 8 | ROM-copy read data, same cycle |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | 8 | Read response data |
| attr_err_o | output | 1 | Invalid attribute seen on previous access |

## Verification
The hardest cases to reach are upper-area accesses whose outcome depends on register state the ports cannot read back directly: a segment whose read and write attributes differ, a neighbouring segment that was never reprogrammed, and segments holding invalid codes. The bench first programs mixed attributes through the configuration port. It then probes the programmed segment and its untouched neighbour, and reads each outcome from which port strobes and from the returned byte. The bench also drives the same upper-area address with shadowing disabled and with the A20 gate low, so that the higher-priority rules are seen to override the segment attributes.

// File: rtl/pc_mem_pkg.sv
package pc_mem_pkg;
  typedef enum logic [1:0] {RT_NONE, RT_RAM, RT_VID, RT_ROM} route_e;
  localparam logic [1:0] ATTR_RAM = 2'd0;
  localparam logic [1:0] ATTR_ROM = 2'd1;
endpackage

// File: rtl/pc_mem_attr_table.sv
module pc_mem_attr_table #(
  parameter int NUM_SEG = 16,
  localparam int SEG_W = $clog2(NUM_SEG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEG_W-1:0] cfg_seg_i,
  input  logic [1:0]       cfg_rd_attr_i,
  input  logic [1:0]       cfg_wr_attr_i,
  input  logic [SEG_W-1:0] seg_i,
  output logic [1:0]       rd_attr_o,
  output logic [1:0]       wr_attr_o
);
  logic [1:0] rd_q [NUM_SEG];
  logic [1:0] wr_q [NUM_SEG];

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q[s] <= pc_mem_pkg::ATTR_ROM;
        wr_q[s] <= pc_mem_pkg::ATTR_ROM;
      end else if (cfg_we_i && cfg_seg_i == SEG_W'(s)) begin
        rd_q[s] <= cfg_rd_attr_i;
        wr_q[s] <= cfg_wr_attr_i;
      end
    end
  end

  assign rd_attr_o = rd_q[seg_i];
  assign wr_attr_o = wr_q[seg_i];

  // R5: configuration lands on the next cycle
  p_cfg_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> rd_q[$past(cfg_seg_i)] == $past(cfg_rd_attr_i)
               && wr_q[$past(cfg_seg_i)] == $past(cfg_wr_attr_i));
endmodule

// File: rtl/pc_mem_decode.sv
module pc_mem_decode
  import pc_mem_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W:0] MEM_BYTES = 33'h0100_0000,
  parameter int              SEG_W     = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              shadow_en_i,
  input  logic [1:0]        rd_attr_i,
  input  logic [1:0]        wr_attr_i,
  output logic [SEG_W-1:0]  seg_o,
  output route_e            route_o,
  output logic              attr_err_o
);
  logic beyond, legacy_win, upper;
  logic [1:0] attr;

  assign beyond     = {1'b0, addr_i} >= MEM_BYTES;
  assign legacy_win = addr_i[ADDR_W-1:19] == (ADDR_W-19)'(1);
  assign upper      = legacy_win && addr_i[18];
  assign seg_o      = addr_i[14 +: SEG_W];
  assign attr       = we_i ? wr_attr_i : rd_attr_i;

  always_comb begin
    route_o    = RT_NONE;
    attr_err_o = 1'b0;
    if (beyond) begin
      route_o = RT_NONE;
    end else if (!legacy_win || !addr_i[17] && !addr_i[18]) begin
      route_o = RT_RAM;
    end else if (!upper) begin
      route_o = RT_VID;
    end else if (!shadow_en_i) begin
      route_o = we_i ? RT_NONE : RT_RAM;
    end else begin
      unique case (attr)
        ATTR_RAM: route_o = RT_RAM;
        ATTR_ROM: route_o = we_i ? RT_NONE : RT_ROM;
        default:  attr_err_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pc_mem_rsp.sv
module pc_mem_rsp
  import pc_mem_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  route_e            route_i,
  input  logic              err_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] vid_rdata_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    unique case (route_i)
      RT_RAM:  rdata_d = ram_rdata_i;
      RT_VID:  rdata_d = vid_rdata_i;
      RT_ROM:  rdata_d = rom_rdata_i;
      default: rdata_d = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= req_i && !we_i;
      err_o   <= req_i && err_i;
      if (req_i && !we_i) rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/pc_mem_router.sv
module pc_mem_router
  import pc_mem_pkg::*;
#(
  parameter int                 ADDR_W    = 32,
  parameter int                 DATA_W    = 8,
  parameter logic [ADDR_W:0]    MEM_BYTES = 33'h0100_0000,
  parameter int                 NUM_SEG   = 16,
  localparam int                SEG_W     = $clog2(NUM_SEG),
  localparam int                ROM_AW    = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              a20_gate_i,
  input  logic              shadow_en_i,
  input  logic              cfg_we_i,
  input  logic [SEG_W-1:0]  cfg_seg_i,
  input  logic [1:0]        cfg_rd_attr_i,
  input  logic [1:0]        cfg_wr_attr_i,
  output logic              ram_req_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              vid_req_o,
  output logic              vid_we_o,
  output logic [ADDR_W-1:0] vid_addr_o,
  output logic [DATA_W-1:0] vid_wdata_o,
  input  logic [DATA_W-1:0] vid_rdata_i,
  output logic              rom_req_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              attr_err_o
);
  logic [ADDR_W-1:0] addr_m;
  logic [SEG_W-1:0]  seg;
  logic [1:0]        rd_attr, wr_attr;
  route_e            route;
  logic              dec_err;

  // address line 20 gate
  always_comb begin
    addr_m     = req_addr_i;
    addr_m[20] = req_addr_i[20] & a20_gate_i;
  end

  pc_mem_attr_table #(.NUM_SEG(NUM_SEG)) i_attr (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_seg_i, .cfg_rd_attr_i, .cfg_wr_attr_i,
    .seg_i(seg), .rd_attr_o(rd_attr), .wr_attr_o(wr_attr)
  );

  pc_mem_decode #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .SEG_W(SEG_W)) i_dec (
    .addr_i(addr_m), .we_i(req_we_i), .shadow_en_i,
    .rd_attr_i(rd_attr), .wr_attr_i(wr_attr),
    .seg_o(seg), .route_o(route), .attr_err_o(dec_err)
  );

  assign ram_req_o   = req_i && route == RT_RAM;
  assign ram_we_o    = req_we_i;
  assign ram_addr_o  = addr_m;
  assign ram_wdata_o = req_wdata_i;
  assign vid_req_o   = req_i && route == RT_VID;
  assign vid_we_o    = req_we_i;
  assign vid_addr_o  = addr_m;
  assign vid_wdata_o = req_wdata_i;
  assign rom_req_o   = req_i && route == RT_ROM;
  assign rom_addr_o  = addr_m[ROM_AW-1:0];

  pc_mem_rsp #(.DATA_W(DATA_W)) i_rsp (
    .clk_i, .rst_ni, .req_i, .we_i(req_we_i), .route_i(route), .err_i(dec_err),
    .ram_rdata_i, .vid_rdata_i, .rom_rdata_i,
    .valid_o(rsp_valid_o), .rdata_o(rsp_rdata_o), .err_o(attr_err_o)
  );

  // R4: at most one store strobed per access
  p_one_port_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_req_o, vid_req_o, rom_req_o}));
  // R1: masked bit 20 never reaches a port while the gate is low
  p_a20_mask_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_req_o || vid_req_o) && !a20_gate_i |-> !ram_addr_o[20]);
  // R6: the ROM copy is read-only
  p_rom_read_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_req_o |-> !req_we_i);
  // R9: nothing beyond installed memory is strobed
  p_beyond_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && {1'b0, addr_m} >= MEM_BYTES |-> !ram_req_o && !vid_req_o && !rom_req_o);
  // R11: read response follows a read request by one cycle
  p_rsp_timing_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !req_we_i |=> rsp_valid_o);
  p_no_rsp_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !req_we_i) |=> !rsp_valid_o);
  // R10: error flag only after an access
  p_err_after_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !attr_err_o);
endmodule

// File: tb/test_pc_mem_router.sv
module test_pc_mem_router;
  logic        clk = 0, rst_ni = 0;
  logic        req = 0, we = 0, gate = 1, shen = 1;
  logic [31:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_seg = '0;
  logic [1:0]  cfg_rd = '0, cfg_wr = '0;
  logic        ram_req, ram_we, vid_req, vid_we, rom_req, rsp_valid, attr_err;
  logic [31:0] ram_addr, vid_addr;
  logic [7:0]  ram_wdata, vid_wdata, ram_rdata, vid_rdata, rom_rdata, rsp_rdata;
  logic [17:0] rom_addr;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  assign ram_rdata = ram_addr[7:0] ^ 8'h5A;
  assign vid_rdata = vid_addr[7:0] ^ 8'hC3;
  assign rom_rdata = rom_addr[7:0] ^ 8'h3C;

  pc_mem_router i_pc_mem_router (
    .clk_i(clk), .rst_ni, .req_i(req), .req_we_i(we), .req_addr_i(addr),
    .req_wdata_i(wdata), .a20_gate_i(gate), .shadow_en_i(shen),
    .cfg_we_i(cfg_we), .cfg_seg_i(cfg_seg), .cfg_rd_attr_i(cfg_rd), .cfg_wr_attr_i(cfg_wr),
    .ram_req_o(ram_req), .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_rdata), .vid_req_o(vid_req), .vid_we_o(vid_we), .vid_addr_o(vid_addr),
    .vid_wdata_o(vid_wdata), .vid_rdata_i(vid_rdata), .rom_req_o(rom_req),
    .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .attr_err_o(attr_err)
  );

  task automatic chk(string req_name, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req_name, act, exp);
    end
  endtask

  // one access; strobes = {ram,vid,rom}; checks strobe, port address and response
  task automatic access(string rq, logic w, logic [31:0] a, logic [7:0] d,
                        logic [2:0] exp_strb, logic [31:0] exp_addr,
                        logic [7:0] exp_rd, logic exp_err);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    #1;
    chk({rq, " strobes"}, {ram_req, vid_req, rom_req}, exp_strb);
    if (ram_req) begin
      chk({rq, " ram addr"}, ram_addr, exp_addr);
      chk({rq, " ram we"}, ram_we, w);
      if (w) chk({rq, " ram wdata"}, ram_wdata, d);
    end
    if (vid_req) begin
      chk({rq, " vid addr"}, vid_addr, exp_addr);
      chk({rq, " vid we"}, vid_we, w);
      if (w) chk({rq, " vid wdata"}, vid_wdata, d);
    end
    if (rom_req) chk({rq, " rom offset"}, rom_addr, exp_addr[17:0]);
    @(posedge clk);
    #1;
    req = 0;
    chk({rq, " R11 valid"}, rsp_valid, !w);
    if (!w) chk({rq, " rdata"}, rsp_rdata, exp_rd);
    chk({rq, " R10 err"}, attr_err, exp_err);
  endtask

  task automatic set_attr(logic [3:0] s, logic [1:0] r, logic [1:0] w);
    @(negedge clk);
    cfg_we = 1; cfg_seg = s; cfg_rd = r; cfg_wr = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic t_reset;
    chk("R11 reset valid", rsp_valid, 0);
    chk("R10 reset err", attr_err, 0);
  endtask

  task automatic t_low_ram;
    access("R2 write low", 1, 32'h0000_1234, 8'hA5, 3'b100, 32'h0000_1234, 0, 0);
    access("R2 read low", 0, 32'h0000_5678, 0, 3'b100, 32'h0000_5678, 8'h78 ^ 8'h5A, 0);
    access("R2 read high", 0, 32'h0020_00F1, 0, 3'b100, 32'h0020_00F1, 8'hF1 ^ 8'h5A, 0);
  endtask

  task automatic t_conv;
    access("R3 read 80000", 0, 32'h0008_1011, 0, 3'b100, 32'h0008_1011, 8'h11 ^ 8'h5A, 0);
    access("R3 write 9FFFF", 1, 32'h0009_FFFF, 8'h3E, 3'b100, 32'h0009_FFFF, 0, 0);
  endtask

  task automatic t_video;
    access("R4 read A0010", 0, 32'h000A_0010, 0, 3'b010, 32'h000A_0010, 8'h10 ^ 8'hC3, 0);
    access("R4 write BFFFF", 1, 32'h000B_FFFF, 8'h77, 3'b010, 32'h000B_FFFF, 0, 0);
  endtask

  task automatic t_upper_reset;
    access("R7 read rom", 0, 32'h000F_0020, 0, 3'b001, 32'h0003_0020, 8'h20 ^ 8'h3C, 0);
    access("R6 write inhibit", 1, 32'h000F_0020, 8'h11, 3'b000, 0, 0, 0);
  endtask

  task automatic t_shadow;
    set_attr(4'd0, 2'd0, 2'd0);
    access("R6 write shadow", 1, 32'h000C_0005, 8'h99, 3'b100, 32'h000C_0005, 0, 0);
    access("R7 read shadow", 0, 32'h000C_0005, 0, 3'b100, 32'h000C_0005, 8'h05 ^ 8'h5A, 0);
    access("R5 neighbour rom", 0, 32'h000C_4001, 0, 3'b001, 32'h0000_4001, 8'h01 ^ 8'h3C, 0);
    set_attr(4'd2, 2'd1, 2'd0);
    access("R5 split wr", 1, 32'h000C_8002, 8'h42, 3'b100, 32'h000C_8002, 0, 0);
    access("R5 split rd", 0, 32'h000C_8002, 0, 3'b001, 32'h0000_8002, 8'h02 ^ 8'h3C, 0);
  endtask

  task automatic t_bad_attr;
    set_attr(4'd15, 2'd2, 2'd3);
    access("R10 bad read", 0, 32'h000F_C000, 0, 3'b000, 0, 8'hFF, 1);
    access("R10 bad write", 1, 32'h000F_C000, 8'h55, 3'b000, 0, 0, 1);
    access("R10 err clears", 0, 32'h0000_0040, 0, 3'b100, 32'h0000_0040, 8'h40 ^ 8'h5A, 0);
  endtask

  task automatic t_shadow_off;
    shen = 0;
    access("R8 read ram", 0, 32'h000F_0020, 0, 3'b100, 32'h000F_0020, 8'h20 ^ 8'h5A, 0);
    access("R8 write drop", 1, 32'h000C_0005, 8'h12, 3'b000, 0, 0, 0);
    access("R8 bad ignored", 0, 32'h000F_C000, 0, 3'b100, 32'h000F_C000, 8'h00 ^ 8'h5A, 0);
    shen = 1;
  endtask

  task automatic t_a20;
    gate = 0;
    access("R1 gate low", 0, 32'h0010_1234, 0, 3'b100, 32'h0000_1234, 8'h34 ^ 8'h5A, 0);
    access("R1 low to video", 1, 32'h001A_0003, 8'h6C, 3'b010, 32'h000A_0003, 0, 0);
    gate = 1;
    access("R1 gate high", 0, 32'h0010_1234, 0, 3'b100, 32'h0010_1234, 8'h34 ^ 8'h5A, 0);
  endtask

  task automatic t_beyond;
    access("R9 read limit", 0, 32'h0100_0000, 0, 3'b000, 0, 8'hFF, 0);
    access("R9 write limit", 1, 32'h0100_0000, 8'h01, 3'b000, 0, 0, 0);
    access("R9 read top", 0, 32'hFFFF_FFFF, 0, 3'b000, 0, 8'hFF, 0);
    access("R9 last byte", 0, 32'h00FF_FFFF, 0, 3'b100, 32'h00FF_FFFF, 8'hFF ^ 8'h5A, 0);
    gate = 0;
    access("R9 masked still beyond", 0, 32'h0110_0000, 0, 3'b000, 0, 8'hFF, 0);
    gate = 1;
  endtask

  initial begin
    fork
      begin
        #3;
        t_reset();
        repeat (2) @(negedge clk);
        rst_ni = 1;
        t_low_ram();
        t_conv();
        t_video();
        t_upper_reset();
        t_shadow();
        t_bad_attr();
        t_shadow_off();
        t_a20();
        t_beyond();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule